// File: doc/BRIEF.md
# I2C Bus Controller with Hardware Direction Tracking

This block connects a chip to a two-wire I2C bus through open-drain SCL and SDA lines. It can act as master or as slave. As master it produces a start condition, sends one address byte from its data buffer, collects the acknowledge, and later produces a stop condition on command. As slave it watches for its own 7-bit address or for the general-call byte, and acknowledges either one. Bus-busy status comes from start and stop conditions seen on the lines, whichever device caused them.

Software controls the block through a 5-bit control word. Start and stop are requested by writing fixed bit patterns to that word. The block keeps the transmit/receive direction flag up to date on its own: it sets the flag from the R/W bit after an address transfer, and clears it when a stop is detected or arbitration is lost. A service-pending flag, which also drives the interrupt output, marks the end of each acknowledged byte slot.

Top module: `i2cDirCtl`

## Requirements
- R1: After reset, both line drivers are released, and `busBusy`, `trxOut`, `mstOut`, `pending` and `irq` are 0.
- R2: Control word bits are mstSel=4, txDir=3, busReq=2, svcRelease=1, ackEn=0. With the bus idle, writing 1 to bits 4..1 makes the block pull SDA low while SCL is high. It then gives 9 SCL clocks: `dataBuf[7:1]` MSB first, `dataBuf[0]` as R/W on clock 8, and SDA released on clock 9. Between the start and the stop, the master changes SDA only while SCL is low.
- R3: In master mode, if the address byte is acknowledged (SDA low on clock 9), `trxOut` becomes the inverse of the R/W bit that was sent.
- R4: In master mode, if the address byte is not acknowledged, `trxOut` keeps its value.
- R5: In slave mode (`mstOut`=0), a received byte whose upper 7 bits equal the own address sets `trxOut` to the received R/W bit. It also copies the byte into `dataBuf`. When ackEn is 1, the block pulls SDA low for the 9th clock.
- R6: A received byte of 0x00 after a start (general call) is handled like an own-address match.
- R7: A received byte that is neither the own address nor 0x00 gets no acknowledge, and `trxOut` and `pending` do not change.
- R8: `busBusy` goes to 1 after a start condition is detected on the bus (SDA falling while SCL is high) and to 0 after a stop condition (SDA rising while SCL is high), whoever drove it.
- R9: `trxOut` goes to 0 when a stop condition is detected.
- R10: If the master releases SDA during an address bit but samples it low while SCL is high, arbitration is lost. `mstOut` and `trxOut` go to 0 and both line drivers are released.
- R11: While busy, after its address byte, writing bits 4..1 = 1101 makes the master raise SDA while SCL is high (a stop). Control writes made before that stop is seen on the bus are ignored.
- R12: `pending` goes to 0 when a start command is accepted. It goes to 1 after the 9th clock of an own transfer or of a matched slave byte. Writing svcRelease=1 clears it. `irq` equals `pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWr | input | 1 | Control word write strobe |
| ctlWrData | input | 5 | Control word: mstSel, txDir, busReq, svcRelease, ackEn (bit 4 down to 0) |
| dataWr | input | 1 | Data buffer write strobe |
| dataWrData | input | 8 | Data buffer write value (address in 7:1, R/W in 0) |
| addrWr | input | 1 | Own-address write strobe |
| addrWrData | input | 7 | Own 7-bit slave address |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| mstOut | output | 1 | Master role flag |
| trxOut | output | 1 | Direction flag, 1 = transmitter |
| busBusy | output | 1 | Bus-busy status |
| pending | output | 1 | Service-pending flag |
| ackEn | output | 1 | Acknowledge enable setting |
| dataBuf | output | 8 | Data buffer contents |
| irq | output | 1 | Interrupt request, follows pending |

## Verification
The master address phase runs through a table of address/R/W/acknowledge combinations. An acknowledged R/W=1 byte is the case that shows the flag is actually inverted. A refused R/W=1 byte shows the flag is left alone rather than always recomputed. In slave mode the bench plays the remote master and sends the own address with each R/W value, the general-call byte, and a foreign address. Each case starts from the opposite direction setting, so every hardware update or non-update is visible. Arbitration loss is forced by holding SDA low against a released 1 bit. Stop handling is probed by writing the control word again while the stop is still under way.

// File: rtl/i2cDirPkg.sv
package i2cDirPkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic loadShift;  // copy data buffer into shifter
    logic shiftOut;   // advance shifter after a transmitted bit
    logic shiftIn;    // shift sampled SDA in on SCL rise
    logic captureRx;  // copy received byte into data buffer
    logic sclLow;     // pull SCL low
    logic sdaLow;     // pull SDA low
  } dpCtrl_t;
endpackage

// File: rtl/i2cDirDatapath.sv
module i2cDirDatapath
  import i2cDirPkg::*;
#(
  parameter int QTR_DIV = 4,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataWrData,
  input  dpCtrl_t           ctrl,
  output logic              tick,
  output logic              sdaS,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              shMsb,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] dataBuf,
  output logic              sclOe,
  output logic              sdaOe
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

  logic [1:0] sclSync, sdaSync;
  logic sclS, sclPrev, sdaPrev;
  logic [CW-1:0] divCnt;
  logic [BYTE_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == CW'(QTR_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      dataBuf <= '0;
    end else begin
      if (ctrl.loadShift) shReg <= dataBuf;
      else if (ctrl.shiftOut) shReg <= {shReg[BYTE_W-2:0], 1'b0};
      else if (ctrl.shiftIn) shReg <= {shReg[BYTE_W-2:0], sdaS};
      if (dataWr) dataBuf <= dataWrData;
      else if (ctrl.captureRx) dataBuf <= shReg;
    end
  end

  assign shMsb  = shReg[BYTE_W-1];
  assign rxByte = shReg;
  assign sclOe  = ctrl.sclLow;
  assign sdaOe  = ctrl.sdaLow;
endmodule

// File: rtl/i2cDirControl.sv
module i2cDirControl
  import i2cDirPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CTL_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  logic              addrWr,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              tick,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              shMsb,
  input  logic [ADDR_W:0]   rxByte,
  output dpCtrl_t           ctrl,
  output logic              mstOut,
  output logic              trxOut,
  output logic              busBusy,
  output logic              pending,
  output logic              ackEn
);
  localparam int BITS = ADDR_W + 1;           // address plus R/W
  localparam int CNT_W = $clog2(BITS + 2);

  typedef enum logic [2:0] {M_IDLE, M_START, M_BIT, M_HOLD, M_STOP, M_LOST} mState_t;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_EVAL, S_ACKW, S_ACKD, S_WAIT} sState_t;

  mState_t mState;
  sState_t sState;
  logic [1:0] q;
  logic [CNT_W-1:0] bitIdx, sCnt;
  logic sclDrv, sdaDrv, sSda, ackSeen, rwSent, stopPend;
  logic [ADDR_W-1:0] ownAddr;

  logic wrOk, startCmd, stopCmd, genWr, masterBitDone, arbLoss, matchNow, slvEn, slvAckDone;

  assign wrOk     = ctlWr && !stopPend;
  assign startCmd = wrOk && !busBusy && mState == M_IDLE && ctlWrData[4:1] == 4'b1111;
  assign stopCmd  = wrOk && busBusy && mState == M_HOLD && ctlWrData[4:1] == 4'b1101;
  assign genWr    = wrOk && !startCmd && !stopCmd;
  assign masterBitDone = mState == M_BIT && tick && q == 2'd3 && bitIdx == CNT_W'(BITS);
  assign arbLoss  = mState == M_BIT && tick && q == 2'd2 && bitIdx < CNT_W'(BITS) && !sdaDrv && !sdaS;
  assign matchNow = (rxByte[ADDR_W:1] == ownAddr) || (rxByte == '0);
  assign slvEn    = !mstOut && mState == M_IDLE;
  assign slvAckDone = sState == S_ACKD && sclFall;

  always_comb begin
    ctrl.loadShift = startCmd;
    ctrl.shiftOut  = mState == M_BIT && tick && q == 2'd3;
    ctrl.shiftIn   = sState == S_ADDR && sclRise;
    ctrl.captureRx = sState == S_EVAL && matchNow;
    ctrl.sclLow    = sclDrv;
    ctrl.sdaLow    = sdaDrv | sSda;
  end

  // flags and registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mstOut <= 1'b0; trxOut <= 1'b0; busBusy <= 1'b0; pending <= 1'b0;
      ackEn <= 1'b0; stopPend <= 1'b0; ownAddr <= '0;
    end else begin
      if (addrWr) ownAddr <= addrWrData;
      if (startDet) busBusy <= 1'b1;
      else if (stopDet) busBusy <= 1'b0;
      if (stopCmd) stopPend <= 1'b1;
      else if (stopDet) stopPend <= 1'b0;
      if (startCmd || genWr) ackEn <= ctlWrData[0];
      if (arbLoss) mstOut <= 1'b0;
      else if (startCmd) mstOut <= 1'b1;
      else if (genWr) mstOut <= ctlWrData[4];
      if (stopDet || arbLoss) trxOut <= 1'b0;
      else if (startCmd) trxOut <= 1'b1;
      else if (masterBitDone && ackSeen) trxOut <= ~rwSent;
      else if (sState == S_EVAL && matchNow) trxOut <= rxByte[0];
      else if (genWr) trxOut <= ctlWrData[3];
      if (startCmd) pending <= 1'b0;
      else if (masterBitDone || slvAckDone) pending <= 1'b1;
      else if (genWr && ctlWrData[1]) pending <= 1'b0;
    end
  end

  // master sequencer: four quarter ticks per SCL period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= M_IDLE; q <= '0; bitIdx <= '0;
      sclDrv <= 1'b0; sdaDrv <= 1'b0; ackSeen <= 1'b0; rwSent <= 1'b0;
    end else begin
      case (mState)
        M_IDLE: if (startCmd) begin mState <= M_START; q <= '0; end
        M_START: if (tick) begin
          if (q == 2'd0) begin sdaDrv <= 1'b1; q <= 2'd1; end
          else begin sclDrv <= 1'b1; mState <= M_BIT; q <= '0; bitIdx <= '0; end
        end
        M_BIT: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: begin
              sdaDrv <= (bitIdx < CNT_W'(BITS)) ? ~shMsb : 1'b0;
              if (bitIdx == CNT_W'(BITS - 1)) rwSent <= shMsb;
            end
            2'd1: sclDrv <= 1'b0;
            2'd2: begin
              if (arbLoss) begin mState <= M_LOST; sdaDrv <= 1'b0; end
              if (bitIdx == CNT_W'(BITS)) ackSeen <= !sdaS;
            end
            default: begin
              sclDrv <= 1'b1;
              bitIdx <= bitIdx + 1'b1;
              if (bitIdx == CNT_W'(BITS)) begin mState <= M_HOLD; sdaDrv <= 1'b0; end
            end
          endcase
        end
        M_HOLD: if (stopCmd) begin mState <= M_STOP; q <= '0; end
        M_STOP: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd0) sdaDrv <= 1'b1;
          else if (q == 2'd1) sclDrv <= 1'b0;
          else begin sdaDrv <= 1'b0; mState <= M_IDLE; end
        end
        default: begin mState <= M_IDLE; sclDrv <= 1'b0; sdaDrv <= 1'b0; end
      endcase
    end
  end

  // slave address receiver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sState <= S_IDLE; sCnt <= '0; sSda <= 1'b0;
    end else if (stopDet) begin
      sState <= S_IDLE; sSda <= 1'b0;
    end else if (startDet && slvEn) begin
      sState <= S_ADDR; sCnt <= '0; sSda <= 1'b0;
    end else begin
      case (sState)
        S_ADDR: if (sclRise) begin
          sCnt <= sCnt + 1'b1;
          if (sCnt == CNT_W'(BITS - 1)) sState <= S_EVAL;
        end
        S_EVAL: sState <= matchNow ? S_ACKW : S_WAIT;
        S_ACKW: if (sclFall) begin sSda <= ackEn; sState <= S_ACKD; end
        S_ACKD: if (sclFall) begin sSda <= 1'b0; sState <= S_WAIT; end
        default: ;
      endcase
    end
  end

  p_sda_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mState == M_BIT && !sclDrv && $past(!sclDrv)) |-> $stable(sdaDrv));
  p_master_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    (masterBitDone && ackSeen) |=> trxOut == !$past(rwSent));
  p_nack_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (masterBitDone && !ackSeen) |=> $stable(trxOut));
  p_slave_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sState == S_EVAL && matchNow) |=> trxOut == $past(rxByte[0]));
  p_no_ack_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sState == S_EVAL && !matchNow) |=> !sSda && $stable(trxOut));
  p_busy_set_r8: assert property (@(posedge clk) disable iff (!rstN) startDet |=> busBusy);
  p_busy_clr_r8: assert property (@(posedge clk) disable iff (!rstN) stopDet |=> !busBusy);
  p_trx_stop_r9: assert property (@(posedge clk) disable iff (!rstN) stopDet |=> !trxOut);
  p_lost_r10: assert property (@(posedge clk) disable iff (!rstN)
    arbLoss |=> (!mstOut && !trxOut && !sclDrv && !sdaDrv));
  p_stop_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stopPend && ctlWr) |=> ($stable(ackEn) && $stable(mstOut)));
  p_pend_start_r12: assert property (@(posedge clk) disable iff (!rstN) startCmd |=> !pending);
endmodule

// File: rtl/i2cDirCtl.sv
module i2cDirCtl
  import i2cDirPkg::*;
#(
  parameter int QTR_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWr,
  input  logic [4:0] ctlWrData,
  input  logic       dataWr,
  input  logic [7:0] dataWrData,
  input  logic       addrWr,
  input  logic [6:0] addrWrData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       mstOut,
  output logic       trxOut,
  output logic       busBusy,
  output logic       pending,
  output logic       ackEn,
  output logic [7:0] dataBuf,
  output logic       irq
);
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  dpCtrl_t ctrl;
  logic tick, sdaS, sclRise, sclFall, startDet, stopDet, shMsb;
  logic [BYTE_W-1:0] rxByte;

  i2cDirDatapath #(.QTR_DIV(QTR_DIV), .BYTE_W(BYTE_W)) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .dataWr(dataWr), .dataWrData(dataWrData), .ctrl(ctrl),
    .tick(tick), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .shMsb(shMsb), .rxByte(rxByte),
    .dataBuf(dataBuf), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  i2cDirControl #(.ADDR_W(ADDR_W), .CTL_W(5)) ctl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlWrData(ctlWrData),
    .addrWr(addrWr), .addrWrData(addrWrData), .tick(tick), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .shMsb(shMsb), .rxByte(rxByte), .ctrl(ctrl), .mstOut(mstOut), .trxOut(trxOut),
    .busBusy(busBusy), .pending(pending), .ackEn(ackEn)
  );

  assign irq = pending;
endmodule

// File: tb/i2cDirCtl_test.sv
module i2cDirCtl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic ctlWr = 0, dataWr = 0, addrWr = 0;
  logic [4:0] ctlWrData = '0;
  logic [7:0] dataWrData = '0;
  logic [6:0] addrWrData = '0;
  logic sclOe, sdaOe, mstOut, trxOut, busBusy, pending, ackEn, irq;
  logic [7:0] dataBuf;
  logic tbScl = 0, tbSdaT = 0, tbSdaM = 0;
  logic sclBus, sdaBus;
  assign sclBus = !(sclOe || tbScl);
  assign sdaBus = !(sdaOe || tbSdaT || tbSdaM);

  i2cDirCtl #(.QTR_DIV(4)) uut (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlWrData(ctlWrData),
    .dataWr(dataWr), .dataWrData(dataWrData), .addrWr(addrWr), .addrWrData(addrWrData),
    .sclIn(sclBus), .sdaIn(sdaBus), .sclOe(sclOe), .sdaOe(sdaOe), .mstOut(mstOut),
    .trxOut(trxOut), .busBusy(busBusy), .pending(pending), .ackEn(ackEn),
    .dataBuf(dataBuf), .irq(irq)
  );

  int total = 0, bad = 0;
  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // remote slave model for master-mode tests
  logic modelOn = 0, mAck = 0, sclP = 1, sdaP = 1;
  int mBits = 0;
  logic [7:0] mCap = '0;
  always @(negedge clk) begin
    if (!modelOn) begin
      mBits <= 0; tbSdaM <= 0;
    end else if (sclBus && sclP && sdaP && !sdaBus) begin
      mBits <= 0; mCap <= '0;
    end else if (sclBus && !sclP) begin
      if (mBits < 8) mCap <= {mCap[6:0], sdaBus};
      mBits <= mBits + 1;
    end else if (!sclBus && sclP) begin
      if (mBits == 8 && mAck) tbSdaM <= 1;
      if (mBits == 9) tbSdaM <= 0;
    end
    sclP <= sclBus; sdaP <= sdaBus;
  end

  task automatic ctlWrite(input logic [4:0] d);
    @(negedge clk); ctlWr = 1; ctlWrData = d;
    @(negedge clk); ctlWr = 0;
  endtask
  task automatic dataWrite(input logic [7:0] d);
    @(negedge clk); dataWr = 1; dataWrData = d;
    @(negedge clk); dataWr = 0;
  endtask
  task automatic waitQ();
    repeat (8) @(negedge clk);
  endtask

  // bench acts as remote master sending one byte to the block
  task automatic slaveXfer(input logic [7:0] b, input logic preTrx, input logic expAck,
                           input logic expTrx, input string req);
    logic ackSeen;
    ctlWrite({1'b0, preTrx, 1'b0, 1'b1, 1'b1});
    tbSdaT = 1; waitQ(); tbScl = 1; waitQ();
    check("R8 busy after start", busBusy, 1);
    for (int i = 7; i >= 0; i--) begin
      tbSdaT = !b[i]; waitQ(); tbScl = 0; waitQ(); tbScl = 1; waitQ();
    end
    tbSdaT = 0; waitQ(); tbScl = 0; waitQ();
    ackSeen = !sdaBus;
    tbScl = 1; waitQ();
    check({req, " ack"}, ackSeen, expAck);
    check({req, " trx"}, trxOut, expTrx);
    check({req, " pending R12"}, pending, expAck);
    check({req, " released"}, sdaOe, 0);
    if (expAck) check({req, " dataBuf"}, dataBuf, b);
    tbSdaT = 1; waitQ(); tbScl = 0; waitQ(); tbSdaT = 0; waitQ();
    check("R8 busy after stop", busBusy, 0);
    check("R9 trx after stop", trxOut, 0);
  endtask

  // {addr7, rw, slaveAcks, expectedTrx}
  localparam logic [9:0] VEC [5] = '{
    {7'h50, 1'b0, 1'b1, 1'b1},
    {7'h2A, 1'b1, 1'b1, 1'b0},
    {7'h11, 1'b1, 1'b0, 1'b1},
    {7'h7F, 1'b0, 1'b0, 1'b1},
    {7'h05, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 sclOe", sclOe, 0);
    check("R1 sdaOe", sdaOe, 0);
    check("R1 busy", busBusy, 0);
    check("R1 trx", trxOut, 0);
    check("R1 mst", mstOut, 0);
    check("R1 pending", pending, 0);
    check("R1 irq", irq, 0);

    @(negedge clk); addrWr = 1; addrWrData = 7'h3C;
    @(negedge clk); addrWr = 0;

    for (int v = 0; v < 5; v++) begin
      modelOn = 1; mAck = VEC[v][1];
      dataWrite({VEC[v][9:3], VEC[v][2]});
      ctlWrite(5'b11111);
      check("R12 pending cleared on start", pending, 0);
      check("R2 master selected", mstOut, 1);
      for (int i = 0; i < 600 && !pending; i++) @(negedge clk);
      check("R2 address bits on bus", mCap, {VEC[v][9:3], VEC[v][2]});
      check(VEC[v][1] ? "R3 trx after ack" : "R4 trx after nack", trxOut, VEC[v][0]);
      check("R12 irq", irq, 1);
      check("R8 busy", busBusy, 1);
      ctlWrite(5'b11011);
      if (v == 0) begin
        ctlWrite(5'b00000);
        check("R11 ackEn kept during stop", ackEn, 1);
        check("R11 mst kept during stop", mstOut, 1);
      end
      for (int i = 0; i < 200 && busBusy; i++) @(negedge clk);
      check("R11 stop seen", busBusy, 0);
      check("R9 trx after stop", trxOut, 0);
      check("R11 lines released", {sclOe, sdaOe}, 0);
      modelOn = 0;
      waitQ();
    end

    slaveXfer(8'h79, 1'b0, 1'b1, 1'b1, "R5 own addr read");
    slaveXfer(8'h78, 1'b1, 1'b1, 1'b0, "R5 own addr write");
    slaveXfer(8'h00, 1'b1, 1'b1, 1'b0, "R6 general call");
    slaveXfer(8'h2B, 1'b1, 1'b0, 1'b1, "R7 foreign addr");

    // arbitration loss against a released 1 bit
    dataWrite(8'h80);
    ctlWrite(5'b11111);
    for (int i = 0; i < 100 && !busBusy; i++) @(negedge clk);
    for (int i = 0; i < 100 && sclBus; i++) @(negedge clk);
    tbSdaT = 1;
    for (int i = 0; i < 100 && mstOut; i++) @(negedge clk);
    check("R10 mst after loss", mstOut, 0);
    check("R10 trx after loss", trxOut, 0);
    check("R10 scl released", sclOe, 0);
    check("R10 sda released", sdaOe, 0);
    waitQ(); tbSdaT = 0; waitQ();
    check("R8 busy after remote stop", busBusy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule